// File: doc/BRIEF.md
# Interrupt Priority and Delegation Resolver

This block decides, once per clock, whether an interrupt should be taken by a hart that has machine, supervisor and user privilege levels. It also decides which privilege level should handle that interrupt. It masks the pending vector with the enable vector. It then makes two passes over the result. The first pass is at machine level, using the bits that are not delegated. The second pass is at supervisor level, using the bits that machine level delegated. Each pass is gated by whether that level is currently allowed to take interrupts. A fixed priority order then picks one source from the winning set.

The result is registered. The valid flag, cause code and target privilege therefore describe the inputs that were present at the previous rising clock edge. A strap input selects between two configurations:

- **Supervisor present:** the full delegation walk described above.
- **Machine only:** delegation, current privilege and status enables are all ignored.

Top module: `irq_arbiter`

## Requirements
- R1: When no bit is set in both `pend` and `enab`, no interrupt is reported (`irq_valid` stays 0).
- R2: With `s_present`=1, the machine-level set is `pend & enab & ~deleg`. It is taken at machine level (`irq_tgt`=3) when that level is enabled. Machine level is enabled when `cur_priv` is not 3, or when `cur_priv` is 3 and `m_ie`=1.
- R3: With `s_present`=1, `cur_priv`=3 and `m_ie`=0, no interrupt is taken at machine level.
- R4: With `s_present`=1, when the machine level takes nothing, the delegated bits `pend & deleg` are masked again with `enab`. If the result is non-zero and supervisor level is enabled, it is taken at supervisor level (`irq_tgt`=1). Supervisor level is enabled when `cur_priv`=0 (user), or when `cur_priv`=1 and `s_ie`=1.
- R5: Supervisor level is never the target while `cur_priv`=3, or while `cur_priv`=1 with `s_ie`=0.
- R6: When machine level is enabled and its set is non-zero but holds none of bits 1, 3, 5, 7, 9, 11, nothing is reported. The delegated bits are not examined in that case.
- R7: Within the chosen set, the priority from highest to lowest is bit 11, 3, 7, 9, 1, 5, and `irq_cause` equals the bit index of the winner.
- R8: With `s_present`=0, `deleg`, `cur_priv`, `m_ie` and `s_ie` have no effect. The highest-priority bit of `pend & enab` is taken at machine level.
- R9: Outputs are registered. They reflect the inputs at the previous rising edge of `clk`. While `rst_n`=0 all outputs are 0.
- R10: While `irq_valid`=0, `irq_cause` and `irq_tgt` are 0. `irq_tgt` is never 0 (user) when valid.
- R11: The privilege encoding is user=0, supervisor=1, machine=3. A `cur_priv` of 2 counts as below machine, with supervisor disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | VEC_W | Pending interrupt bits |
| enab | input | VEC_W | Interrupt enable bits |
| deleg | input | VEC_W | Machine-to-supervisor delegation bits |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| s_present | input | 1 | Strap: supervisor level implemented |
| irq_valid | output | 1 | An interrupt is to be taken |
| irq_cause | output | 4 | Cause code (bit index of the chosen source) |
| irq_tgt | output | 2 | Privilege that handles the interrupt |

## Verification
The machine-level pass and the supervisor-level pass can both have candidates in the same cycle. One group of enabled pending bits is left undelegated while another group is delegated. Current privilege and status enables are then swept so that each pass in turn is either enabled or blocked.

A behavioural reference model in the bench recomputes the expected winner and target from the previous cycle's inputs. It is compared with the outputs on every clock. This confirms that the machine level wins when it is enabled and holds a recognised source. It also confirms that a machine set with no recognised source blocks the supervisor pass.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] pend,
  input  logic [VEC_W-1:0] enab,
  input  logic [VEC_W-1:0] deleg,
  input  logic [1:0]       cur_priv,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             s_present,
  output logic             irq_valid,
  output logic [3:0]       irq_cause,
  output logic [1:0]       irq_tgt
);
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  function automatic logic [4:0] pick(input logic [VEC_W-1:0] v);
    if      (v[11]) pick = {1'b1, 4'd11};
    else if (v[3])  pick = {1'b1, 4'd3};
    else if (v[7])  pick = {1'b1, 4'd7};
    else if (v[9])  pick = {1'b1, 4'd9};
    else if (v[1])  pick = {1'b1, 4'd1};
    else if (v[5])  pick = {1'b1, 4'd5};
    else            pick = 5'd0;
  endfunction

  wire [VEC_W-1:0] ena   = pend & enab;
  wire [VEC_W-1:0] m_set = ena & ~deleg;
  wire [VEC_W-1:0] dlg   = pend & deleg;
  wire [VEC_W-1:0] s_set = dlg & enab;
  wire m_on = (cur_priv != PRV_M) | m_ie;
  wire s_on = s_present & ((cur_priv == PRV_U) | ((cur_priv == PRV_S) & s_ie));

  logic [4:0] sel;
  logic [1:0] tgt;

  always_comb begin
    sel = 5'd0;
    tgt = PRV_U;
    if (ena != '0) begin
      if (!s_present) begin
        sel = pick(ena);
        tgt = PRV_M;
      end else if (m_on && m_set != '0) begin
        sel = pick(m_set);
        tgt = PRV_M;
      end else if (s_on && s_set != '0) begin
        sel = pick(s_set);
        tgt = PRV_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_cause <= 4'd0;
      irq_tgt   <= PRV_U;
    end else begin
      irq_valid <= sel[4];
      irq_cause <= sel[4] ? sel[3:0] : 4'd0;
      irq_tgt   <= sel[4] ? tgt : PRV_U;
    end
  end

  assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & enab) == '0) |=> !irq_valid);

  assert_mie_blocks_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_present && cur_priv == PRV_M && !m_ie) |=> !(irq_valid && irq_tgt == PRV_M));

  assert_s_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == PRV_M || (cur_priv == PRV_S && !s_ie)) |=> !(irq_valid && irq_tgt == PRV_S));

  assert_monly_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_present && (pend & enab) != '0) |=> (!irq_valid || irq_tgt == PRV_M));

  assert_known_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_cause == 4'd11 || irq_cause == 4'd3 || irq_cause == 4'd7 ||
                   irq_cause == 4'd9 || irq_cause == 4'd1 || irq_cause == 4'd5));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_cause == 4'd0 && irq_tgt == PRV_U));

  assert_never_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_tgt != PRV_U);
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] pend = '0, enab = '0, deleg = '0;
  logic [1:0] cur_priv = 2'd3;
  logic m_ie = 0, s_ie = 0, s_present = 1;
  logic irq_valid;
  logic [3:0] irq_cause;
  logic [1:0] irq_tgt;
  int errors = 0, checks = 0;
  logic done = 0;

  always #10 clk = ~clk;

  irq_arbiter #(.VEC_W(W)) dut (.*);

  function automatic logic [6:0] model(input logic [W-1:0] p, e, d, input logic [1:0] pr,
                                       input logic mi, si, sp);
    int ord[6] = '{11, 3, 7, 9, 1, 5};
    logic [W-1:0] cand;
    logic [1:0] t;
    logic menab, senab;
    cand = '0; t = 2'd0;
    menab = (pr != 2'd3) || mi;
    senab = sp && (pr == 2'd0 || (pr == 2'd1 && si));
    if ((p & e) == '0) return 7'd0;
    if (!sp) begin cand = p & e; t = 2'd3; end
    else if (menab && (p & e & ~d) != '0) begin cand = p & e & ~d; t = 2'd3; end
    else if (senab && (p & d & e) != '0) begin cand = p & d & e; t = 2'd1; end
    foreach (ord[i]) if (cand[ord[i]]) return {1'b1, 4'(ord[i]), t};
    return 7'd0;
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    checks++;
    if ({irq_valid, irq_cause, irq_tgt} !== exp) begin
      errors++;
      $display("FAIL %s: got v=%0b c=%0d t=%0d expected v=%0b c=%0d t=%0d", tag,
               irq_valid, irq_cause, irq_tgt, exp[6], exp[5:2], exp[1:0]);
    end
  endtask

  task automatic step(input string tag, input logic [W-1:0] p, e, d, input logic [1:0] pr,
                      input logic mi, si, sp);
    logic [6:0] exp;
    pend = p; enab = e; deleg = d; cur_priv = pr; m_ie = mi; s_ie = si; s_present = sp;
    exp = model(p, e, d, pr, mi, si, sp);
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    @(negedge clk);
    pend = 16'h0AAA; enab = 16'hFFFF;
    @(negedge clk);
    check("R9 reset", 7'd0);
    rst_n = 1;
    step("R1 empty", 16'h0AAA, 16'h0000, 16'h0000, 2'd3, 1, 1, 1);
    check("R1 empty", 7'd0);
    step("R2 M in M", 16'h0880, 16'h0FFF, 16'h0000, 2'd3, 1, 0, 1);
    check("R2 M in M", {1'b1, 4'd11, 2'd3});
    step("R3 MIE off", 16'h0880, 16'h0FFF, 16'h0000, 2'd3, 0, 1, 1);
    check("R3 MIE off", 7'd0);
    step("R2 from U", 16'h0080, 16'h0FFF, 16'h0000, 2'd0, 0, 0, 1);
    check("R2 from U", {1'b1, 4'd7, 2'd3});
    step("R4 S from U", 16'h0222, 16'h0FFF, 16'h0222, 2'd0, 0, 0, 1);
    check("R4 S from U", {1'b1, 4'd9, 2'd1});
    step("R5 S blocked", 16'h0222, 16'h0FFF, 16'h0222, 2'd1, 1, 0, 1);
    check("R5 S blocked", 7'd0);
    step("R5 S in M", 16'h0222, 16'h0FFF, 16'h0222, 2'd3, 1, 1, 1);
    check("R5 S in M", 7'd0);
    step("R4 S with SIE", 16'h0022, 16'h0FFF, 16'h0222, 2'd1, 0, 1, 1);
    check("R4 S with SIE", {1'b1, 4'd1, 2'd1});
    step("R2 M beats S", 16'h0228, 16'h0FFF, 16'h0220, 2'd1, 0, 1, 1);
    check("R2 M beats S", {1'b1, 4'd3, 2'd3});
    step("R4 fallthrough", 16'h0228, 16'h0FFF, 16'h0220, 2'd3, 0, 1, 1);
    check("R4 fallthrough", 7'd0);
    step("R6 odd bit", 16'h0201, 16'h0FFF, 16'h0200, 2'd0, 0, 0, 1);
    check("R6 odd bit", 7'd0);
    step("R7 order", 16'h02A2, 16'h0FFF, 16'h0000, 2'd3, 1, 0, 1);
    check("R7 order", {1'b1, 4'd7, 2'd3});
    step("R8 M only", 16'h0202, 16'h0FFF, 16'hFFFF, 2'd3, 0, 0, 0);
    check("R8 M only", {1'b1, 4'd9, 2'd3});
    step("R11 priv2", 16'h0200, 16'h0FFF, 16'h0200, 2'd2, 0, 1, 1);
    check("R11 priv2", 7'd0);
    step("R11 priv2 M", 16'h0008, 16'h0FFF, 16'h0000, 2'd2, 0, 0, 1);
    check("R11 priv2 M", {1'b1, 4'd3, 2'd3});
    for (int n = 0; n < 3000; n++) begin
      step("R7 random", W'($urandom) & 16'h0FFF, W'($urandom), W'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end
    rst_n = 0;
    @(negedge clk);
    check("R9 reset again", 7'd0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule